// File: doc/BRIEF.md
# Prefixed Add-Immediate Decode and Execute Unit

This unit takes a stream of 32-bit instruction words, each paired with its fetch address, and carries out the add-immediate operation in two encodings. The first is a single standalone word with a 16-bit signed immediate. The second is a two-word prefixed pair: a prefix word supplies an 18-bit upper immediate part and a PC-relative selector bit, and the suffix word that follows it carries the lower 16 bits. Joining the two parts gives a 34-bit signed immediate. The unit returns a 64-bit result and the number of the destination register.

The base operand comes from one combinational register-file read port, and its index is taken straight from the incoming word. A base index of zero stands for the constant zero. In the PC-relative form, the base is the fetch address of the prefix word instead. The unit holds a prefix until the next valid word arrives. If that word is not a suffix, it flags an illegal sequence. A PC-relative pair that also names a nonzero base register is flagged as an invalid form.

Top module: `pfx_addi_unit`

## Requirements
- R1: A word with opcode 14 in `in_word[31:26]`, accepted with no prefix pending, is standalone. Its fields are destination `[25:21]`, base `[20:16]` and signed immediate `[15:0]`. One cycle after acceptance, `out_valid` pulses, `out_rt` is the destination and `out_value` is the base register value plus the sign-extended immediate.
- R2: When the base field is 0, the constant zero is added in place of the read-port data, for both the standalone form and the prefixed form with the selector clear.
- R3: A word is a prefix when `[31:26]`=1, `[25:24]`=2'b10 and `[23]`=0. Its selector is `[20]` and its upper immediate is `[17:0]`. Bits `[22:21]` and `[19:18]` are ignored. An accepted prefix produces no strobe.
- R4: A prefix followed by a suffix word with the selector clear yields the base register value plus the sign extension of {prefix[17:0], suffix[15:0]}, one cycle after the suffix is accepted.
- R5: With the selector set, the result is the fetch address of the prefix word plus the sign-extended 34-bit immediate, and the read-port data is not used.
- R6: With the selector set and a nonzero base field in the suffix, `out_badform` pulses for one cycle instead of `out_valid`.
- R7: When a prefix is pending and the next accepted word does not have opcode 14, `out_illegal` pulses, the pair is discarded and the following word is decoded as fresh.
- R8: While `in_valid` is low, no word is accepted, all three strobes are low on the next cycle, and a pending prefix is kept across the gap.
- R9: A synchronous active-high reset clears the pending prefix and the strobes.
- R10: A word that is neither a standalone word nor a prefix, accepted with nothing pending, produces no strobe.
- R11: At most one of `out_valid`, `out_illegal` and `out_badform` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Instruction word |
| in_addr | input | 64 | Fetch address of the word |
| rd_idx | output | 5 | Register-file read index (base field of the word) |
| rd_data | input | 64 | Register-file read data for rd_idx, same cycle |
| out_valid | output | 1 | Result strobe |
| out_rt | output | 5 | Destination register number |
| out_value | output | 64 | Computed result |
| out_illegal | output | 1 | Prefix not followed by a suffix |
| out_badform | output | 1 | PC-relative pair with nonzero base field |

## Verification
The standalone form is tried with a negative immediate on a nonzero register and with base field zero while register 0 holds a nonzero value, which separates a true constant zero from a register read. Prefixed pairs are tried with an all-ones upper part, so that sign extension from bit 33 is tested rather than from bit 15. The PC-relative pair uses different prefix and suffix addresses, which shows which address is added, and its prefix has the reserved bits set. Idle gaps inside a pair, a non-suffix word after a prefix, a reset between prefix and suffix, and an unrelated opcode test the sequencing: each of these cases changes how the next word is read.

// File: rtl/pfx_addi_pkg.sv
package pfx_addi_pkg;

  localparam int WORD_W   = 32;
  localparam int RIDX_W   = 5;
  localparam int LO_IMM_W = 16;
  localparam int HI_IMM_W = 18;
  localparam int IMM_W    = LO_IMM_W + HI_IMM_W;

  localparam logic [5:0] OPC_ADDI   = 6'd14;
  localparam logic [5:0] OPC_PREFIX = 6'd1;
  localparam logic [1:0] PFX_TYPE   = 2'b10;

  typedef enum logic [1:0] {
    WK_OTHER  = 2'd0,
    WK_ADDI   = 2'd1,
    WK_PREFIX = 2'd2
  } word_kind_e;

  typedef struct packed {
    logic [RIDX_W-1:0]   rt;
    logic [RIDX_W-1:0]   ra;
    logic [LO_IMM_W-1:0] lo_imm;
    logic                rel;
    logic [HI_IMM_W-1:0] hi_imm;
  } word_fields_t;

endpackage

// File: rtl/pfx_word_decode.sv
module pfx_word_decode
  import pfx_addi_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output word_kind_e        kind,
  output word_fields_t      fields
);

  logic [5:0] opc;
  logic       is_pfx;
  logic       unused_rsvd;

  assign opc    = word[31:26];
  assign is_pfx = (opc == OPC_PREFIX) && (word[25:24] == PFX_TYPE) && !word[23];

  always_comb begin
    if (opc == OPC_ADDI)  kind = WK_ADDI;
    else if (is_pfx)      kind = WK_PREFIX;
    else                  kind = WK_OTHER;
  end

  assign fields.rt     = word[25:21];
  assign fields.ra     = word[20:16];
  assign fields.lo_imm = word[15:0];
  assign fields.rel    = word[20];
  assign fields.hi_imm = word[17:0];

  assign unused_rsvd = ^{word[22:21], word[19:18]};

endmodule

// File: rtl/pfx_hold.sv
module pfx_hold
  import pfx_addi_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                consume,
  input  logic                rel_in,
  input  logic [HI_IMM_W-1:0] hi_in,
  input  logic [ADDR_W-1:0]   addr_in,
  output logic                pend,
  output logic                rel,
  output logic [HI_IMM_W-1:0] hi,
  output logic [ADDR_W-1:0]   addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (load) begin
      pend <= 1'b1;
    end else if (consume) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rel  <= rel_in;
      hi   <= hi_in;
      addr <= addr_in;
    end
  end

  assert_load_sets_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> pend);

  assert_idle_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !consume) |=> ($stable(pend) && $stable(hi) && $stable(addr)));

endmodule

// File: rtl/pfx_exec.sv
module pfx_exec
  import pfx_addi_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go_std,
  input  logic                go_pfx,
  input  logic                flag_ill,
  input  logic                flag_bad,
  input  logic                pfx_rel,
  input  logic [HI_IMM_W-1:0] pfx_hi,
  input  logic [XLEN-1:0]     pfx_addr,
  input  logic [RIDX_W-1:0]   rt,
  input  logic [RIDX_W-1:0]   ra,
  input  logic [LO_IMM_W-1:0] lo_imm,
  input  logic [XLEN-1:0]     ra_data,
  output logic                out_valid,
  output logic                out_illegal,
  output logic                out_badform,
  output logic [RIDX_W-1:0]   out_rt,
  output logic [XLEN-1:0]     out_value
);

  localparam int EXT_LO = XLEN - LO_IMM_W;
  localparam int EXT_HI = XLEN - IMM_W;

  logic [XLEN-1:0] imm_short;
  logic [XLEN-1:0] imm_long;
  logic [XLEN-1:0] base_val;
  logic [XLEN-1:0] addend;
  logic [XLEN-1:0] sum;

  assign imm_short = {{EXT_LO{lo_imm[LO_IMM_W-1]}}, lo_imm};
  assign imm_long  = {{EXT_HI{pfx_hi[HI_IMM_W-1]}}, pfx_hi, lo_imm};

  always_comb begin
    if (go_pfx && pfx_rel)  base_val = pfx_addr;
    else if (ra == '0)      base_val = '0;
    else                    base_val = ra_data;
  end

  assign addend = go_pfx ? imm_long : imm_short;
  assign sum    = base_val + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_badform <= 1'b0;
    end else begin
      out_valid   <= go_std || go_pfx;
      out_illegal <= flag_ill;
      out_badform <= flag_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (go_std || go_pfx) begin
      out_rt    <= rt;
      out_value <= sum;
    end
  end

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, out_illegal, out_badform}));

endmodule

// File: rtl/pfx_addi_unit.sv
module pfx_addi_unit
  import pfx_addi_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_word,
  input  logic [XLEN-1:0]     in_addr,
  output logic [RIDX_W-1:0]   rd_idx,
  input  logic [XLEN-1:0]     rd_data,
  output logic                out_valid,
  output logic [RIDX_W-1:0]   out_rt,
  output logic [XLEN-1:0]     out_value,
  output logic                out_illegal,
  output logic                out_badform
);

  word_kind_e      kind;
  word_fields_t    fld;
  logic            pend;
  logic            h_rel;
  logic [HI_IMM_W-1:0] h_hi;
  logic [XLEN-1:0] h_addr;

  logic go_std, load_pfx, pair, pair_ok, flag_ill, flag_bad, go_pfx;

  pfx_word_decode u_dec (
    .word   (in_word),
    .kind   (kind),
    .fields (fld)
  );

  assign rd_idx = fld.ra;

  assign go_std   = in_valid && !pend && (kind == WK_ADDI);
  assign load_pfx = in_valid && !pend && (kind == WK_PREFIX);
  assign pair     = in_valid && pend;
  assign pair_ok  = pair && (kind == WK_ADDI);
  assign flag_ill = pair && (kind != WK_ADDI);
  assign flag_bad = pair_ok && h_rel && (fld.ra != '0);
  assign go_pfx   = pair_ok && !flag_bad;

  pfx_hold #(.ADDR_W(XLEN)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (load_pfx),
    .consume (pair),
    .rel_in  (fld.rel),
    .hi_in   (fld.hi_imm),
    .addr_in (in_addr),
    .pend    (pend),
    .rel     (h_rel),
    .hi      (h_hi),
    .addr    (h_addr)
  );

  pfx_exec #(.XLEN(XLEN)) u_exec (
    .clk         (clk),
    .rst         (rst),
    .go_std      (go_std),
    .go_pfx      (go_pfx),
    .flag_ill    (flag_ill),
    .flag_bad    (flag_bad),
    .pfx_rel     (h_rel),
    .pfx_hi      (h_hi),
    .pfx_addr    (h_addr),
    .rt          (fld.rt),
    .ra          (fld.ra),
    .lo_imm      (fld.lo_imm),
    .ra_data     (rd_data),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_badform (out_badform),
    .out_rt      (out_rt),
    .out_value   (out_value)
  );

  assert_pair_consumed_R7: assert property (@(posedge clk) disable iff (rst)
    (pend && in_valid) |=> !pend);

  assert_no_accept_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_illegal && !out_badform));

  assert_standalone_result_R1: assert property (@(posedge clk) disable iff (rst)
    (!pend && in_valid && in_word[31:26] == OPC_ADDI) |=>
      (out_valid && out_rt == $past(in_word[25:21])));

  assert_other_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (!pend && in_valid && kind == WK_OTHER) |=> (!out_valid && !out_illegal && !out_badform && !pend));

  assert_badform_only_R6: assert property (@(posedge clk) disable iff (rst)
    (pend && h_rel && in_valid && in_word[31:26] == OPC_ADDI && in_word[20:16] != 5'd0)
      |=> (out_badform && !out_valid));

endmodule

// File: tb/tb_pfx_addi_unit.sv
module tb_pfx_addi_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_word;
  logic [63:0] in_addr;
  logic [4:0]  rd_idx;
  logic [63:0] rd_data;
  logic        out_valid;
  logic [4:0]  out_rt;
  logic [63:0] out_value;
  logic        out_illegal;
  logic        out_badform;

  logic [63:0] rf [32];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data = rf[rd_idx];

  pfx_addi_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_addr(in_addr), .rd_idx(rd_idx), .rd_data(rd_data),
    .out_valid(out_valid), .out_rt(out_rt), .out_value(out_value),
    .out_illegal(out_illegal), .out_badform(out_badform)
  );

  function automatic logic [31:0] mk_addi(input logic [4:0] rt, input logic [4:0] ra,
                                          input logic [15:0] si);
    return {6'd14, rt, ra, si};
  endfunction

  function automatic logic [31:0] mk_pfx(input logic r, input logic [17:0] hi,
                                         input logic [1:0] rsv_a, input logic [1:0] rsv_b);
    return {6'd1, 2'b10, 1'b0, rsv_a, r, rsv_b, hi};
  endfunction

  function automatic logic [63:0] sx16(input logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction

  function automatic logic [63:0] sx34(input logic [17:0] hi, input logic [15:0] lo);
    return {{30{hi[17]}}, hi, lo};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [63:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0; in_word = 32'h0; in_addr = 64'h0;
  endtask

  task automatic check_strobes(input string req, input logic v, input logic il, input logic bf);
    check(req, {61'd0, out_valid, out_illegal, out_badform}, {61'd0, v, il, bf});
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; in_word = '0; in_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_strobes("R9 reset strobes", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_standalone;
    send(mk_addi(5'd3, 5'd5, 16'hFFFE), 64'h200);
    check_strobes("R1 strobe", 1'b1, 1'b0, 1'b0);
    check("R1 rt", {59'd0, out_rt}, 64'd3);
    check("R1 value", out_value, rf[5] + sx16(16'hFFFE));
    @(negedge clk);
    check_strobes("R8 strobe drops when idle", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_base;
    send(mk_addi(5'd9, 5'd0, 16'h1234), 64'h204);
    check("R2 standalone zero base", out_value, 64'h1234);
    send(mk_pfx(1'b0, 18'h00001, 2'b00, 2'b00), 64'h300);
    send(mk_addi(5'd10, 5'd0, 16'h0002), 64'h304);
    check("R2 prefixed zero base", out_value, 64'h0000_0000_0001_0002);
  endtask

  task automatic t_prefixed_r0;
    send(mk_pfx(1'b0, 18'h3FFFF, 2'b00, 2'b00), 64'h400);
    check_strobes("R3 prefix silent", 1'b0, 1'b0, 1'b0);
    send(mk_addi(5'd12, 5'd7, 16'h0000), 64'h404);
    check_strobes("R4 strobe", 1'b1, 1'b0, 1'b0);
    check("R4 rt", {59'd0, out_rt}, 64'd12);
    check("R4 value", out_value, rf[7] + sx34(18'h3FFFF, 16'h0000));
  endtask

  task automatic t_pcrel;
    send(mk_pfx(1'b1, 18'h00000, 2'b11, 2'b11), 64'h1000);
    check_strobes("R3 reserved bits ignored", 1'b0, 1'b0, 1'b0);
    send(mk_addi(5'd4, 5'd0, 16'h0010), 64'h1004);
    check_strobes("R5 strobe", 1'b1, 1'b0, 1'b0);
    check("R5 value uses prefix address", out_value, 64'h1010);
    send(mk_pfx(1'b1, 18'h3FFFF, 2'b00, 2'b00), 64'h8000);
    send(mk_addi(5'd4, 5'd0, 16'hFFF0), 64'h8004);
    check("R5 negative offset", out_value, 64'h8000 + sx34(18'h3FFFF, 16'hFFF0));
  endtask

  task automatic t_badform;
    logic [63:0] prev;
    prev = out_value;
    send(mk_pfx(1'b1, 18'h00001, 2'b00, 2'b00), 64'h2000);
    send(mk_addi(5'd6, 5'd5, 16'h0001), 64'h2004);
    check_strobes("R6 badform strobe", 1'b0, 1'b0, 1'b1);
    check("R6 value untouched", out_value, prev);
    send(mk_addi(5'd8, 5'd5, 16'h0001), 64'h2008);
    check("R6 next word standalone", out_value, rf[5] + 64'd1);
  endtask

  task automatic t_illegal;
    send(mk_pfx(1'b0, 18'h00002, 2'b00, 2'b00), 64'h3000);
    send({6'd31, 26'h0ABCDEF}, 64'h3004);
    check_strobes("R7 illegal strobe", 1'b0, 1'b1, 1'b0);
    send(mk_addi(5'd2, 5'd7, 16'h0005), 64'h3008);
    check_strobes("R7 fresh decode strobe", 1'b1, 1'b0, 1'b0);
    check("R7 fresh decode value", out_value, rf[7] + 64'd5);
  endtask

  task automatic t_gap;
    send(mk_pfx(1'b0, 18'h00003, 2'b00, 2'b00), 64'h5000);
    repeat (4) begin
      @(negedge clk);
      check_strobes("R8 no strobe in gap", 1'b0, 1'b0, 1'b0);
    end
    send(mk_addi(5'd11, 5'd5, 16'h0000), 64'h5010);
    check("R8 pair survives gap", out_value, rf[5] + 64'h0000_0000_0003_0000);
  endtask

  task automatic t_reset_mid;
    send(mk_pfx(1'b0, 18'h00007, 2'b00, 2'b00), 64'h6000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    send(mk_addi(5'd13, 5'd5, 16'h0003), 64'h6004);
    check("R9 prefix cleared by reset", out_value, rf[5] + 64'd3);
  endtask

  task automatic t_other;
    send({6'd31, 26'h1234567}, 64'h7000);
    check_strobes("R10 other opcode silent", 1'b0, 1'b0, 1'b0);
    send({6'd1, 2'b01, 1'b0, 23'h0}, 64'h7004);
    check_strobes("R10 wrong prefix type silent", 1'b0, 1'b0, 1'b0);
    send(mk_addi(5'd1, 5'd5, 16'h0001), 64'h7008);
    check("R10 no prefix latched", out_value, rf[5] + 64'd1);
    check_strobes("R11 single strobe", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 64'h1000 * i + 64'h77;
    rf[0] = 64'hDEAD_BEEF_0000_0001;
    rf[5] = 64'd100;
    rf[7] = 64'd1000000;
    t_reset();
    t_standalone();
    t_zero_base();
    t_prefixed_r0();
    t_pcrel();
    t_badform();
    t_illegal();
    t_gap();
    t_reset_mid();
    t_other();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule